// File: doc/BRIEF.md
# Register-Driven Atomic Reservation Unit

This peripheral lets software perform a read-modify-write on one memory word that either completes without interference or reports that it was disturbed. Software writes a word address into the address register. The unit fetches that word over its memory master port, places it in the data register and opens a reservation. Software reads the data register, computes a new value and writes it back. While the reservation is open, the unit records four kinds of disturbance:

- another master reading the reserved word,
- the bus lock being granted to another master,
- an interrupt being taken,
- an error response from memory.

If any of these has been recorded when the data register is written, the store is dropped. Software then reads the status register and treats any set watch flag as a failed attempt, usually retrying from the address write.

The register port is a simple valid/ready slave with byte offsets. Reads return data in the same cycle and have no side effects. A register write that arrives while a memory transaction is in flight is held off with ready low until the transaction ends. The memory side issues single-beat requests and never has more than one outstanding.

Top module: `llsc_unit`

## Requirements
- R1: A write to the address register (offset 0x0) issues one memory read of that word address. On a good response, the returned word appears in the data register (offset 0x4) and a reservation opens.
- R2: A write to the address register clears all four watch flags and closes any reservation that was open before it.
- R3: Reading any register causes no memory request.
- R4: A data-register write made while a reservation is open and no watch flag is set issues one memory write of the written value to the latched address. The flags stay clear when the store completes without error.
- R5: Status bit positions are bit0 read watch, bit1 lock watch, bit2 interrupt watch and bit3 bus-error watch. The watch sources are as follows:
  - A snooped read whose address equals the reserved word sets bit0; a snooped read of any other address has no effect.
  - A lock grant to another master sets bit1.
  - An interrupt-taken pulse sets bit2.
  - An error response on either the fetch or the store sets bit3.
- R6: If any watch flag is set when a data-register write is accepted, or a watch event arrives in that same cycle, no memory write is issued and the memory word keeps its old value.
- R7: A data-register write with no open reservation issues no memory request and sets bit0.
- R8: Status bit4 (busy) reads 1 while a fetch or store is outstanding. While busy, register writes see ready low and take effect only after the transaction ends.
- R9: Watch events that arrive while no reservation is open leave the flags unchanged.
- R10: A memory request holds valid, address and write-enable steady until ready is seen.
- R11: The address register reads back the latched word address. Writes to the status register (offset 0x8) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | RAW (4) | Byte offset of the register |
| reg_wdata | input | DW (32) | Register write data |
| reg_ready | output | 1 | Access accepted (low stalls writes while busy) |
| reg_rdata | output | DW (32) | Register read data, same cycle |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = store, 0 = fetch |
| mem_req_addr | output | AW (16) | Word address |
| mem_req_wdata | output | DW (32) | Store data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_rdata | input | DW (32) | Fetched word |
| mem_rsp_err | input | 1 | Error response |
| snoop_valid | input | 1 | Another master reads memory this cycle |
| snoop_addr | input | AW (16) | Word address of that read |
| lock_grant_other | input | 1 | Bus lock granted to another master |
| irq_taken | input | 1 | Interrupt-taken pulse |

## Verification
The hardest case to reach from the ports is a watch event that lands in the very cycle the data-register write is accepted, so that no flag is visible beforehand but the store must still be dropped. The bench raises the interrupt input on the same falling edge on which it presents the data write, with no stall pending, so that both meet at one rising edge. It then confirms that the memory word and the access count are unchanged. A second hard case is a data write stalled behind a slow fetch. The bench stretches the response latency and issues the data write immediately after the address write, then counts the stall cycles and confirms that the store lands once the fetch ends.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_WAIT,
    ST_STORE_REQ,
    ST_STORE_WAIT
  } llsc_state_e;

  localparam int OFS_ADDR = 0;
  localparam int OFS_DATA = 4;
  localparam int OFS_STAT = 8;

  localparam int NUM_WATCH = 4;
  localparam int W_READ    = 0;
  localparam int W_LOCK    = 1;
  localparam int W_IRQ     = 2;
  localparam int W_BUSERR  = 3;
  localparam int B_BUSY    = 4;

endpackage

// File: rtl/llsc_rst_sync.sv
module llsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/llsc_mem_seq.sv
module llsc_mem_seq
  import llsc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_go,
  input  logic          store_go,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          busy,
  output logic          fetch_ok,
  output logic          fetch_err,
  output logic          store_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic          mem_rsp_err
);

  llsc_state_e   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          cap_en;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_go)      state_d = ST_FETCH_REQ;
        else if (store_go) state_d = ST_STORE_REQ;
      end
      ST_FETCH_REQ:  if (mem_req_ready) state_d = ST_FETCH_WAIT;
      ST_FETCH_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      ST_STORE_REQ:  if (mem_req_ready) state_d = ST_STORE_WAIT;
      ST_STORE_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign cap_en = (state_q == ST_IDLE) && (fetch_go || store_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      addr_q  <= go_addr;
      wdata_q <= go_wdata;
    end
  end

  assign mem_req_valid = (state_q == ST_FETCH_REQ) || (state_q == ST_STORE_REQ);
  assign mem_req_we    = (state_q == ST_STORE_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  assign busy      = (state_q != ST_IDLE);
  assign fetch_ok  = (state_q == ST_FETCH_WAIT) && mem_rsp_valid && !mem_rsp_err;
  assign fetch_err = (state_q == ST_FETCH_WAIT) && mem_rsp_valid &&  mem_rsp_err;
  assign store_err = (state_q == ST_STORE_WAIT) && mem_rsp_valid &&  mem_rsp_err;
  assign rsp_rdata = mem_rsp_rdata;

endmodule

// File: rtl/llsc_watch.sv
module llsc_watch
  import llsc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 resv,
  input  logic [AW-1:0]        resv_addr,
  input  logic                 snoop_valid,
  input  logic [AW-1:0]        snoop_addr,
  input  logic                 lock_other,
  input  logic                 irq_taken,
  input  logic                 fetch_err,
  input  logic                 store_err,
  input  logic                 orphan_store,
  output logic [NUM_WATCH-1:0] flags,
  output logic [NUM_WATCH-1:0] live_evt
);

  logic [NUM_WATCH-1:0] set_src;
  logic [NUM_WATCH-1:0] flag_q;

  always_comb begin
    set_src           = '0;
    set_src[W_READ]   = (resv && snoop_valid && (snoop_addr == resv_addr)) || orphan_store;
    set_src[W_LOCK]   = resv && lock_other;
    set_src[W_IRQ]    = resv && irq_taken;
    set_src[W_BUSERR] = fetch_err || store_err;
  end

  for (genvar i = 0; i < NUM_WATCH; i++) begin : g_flag
    logic en;
    assign en = clr || set_src[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (en) begin
        flag_q[i] <= !clr;
      end
    end
  end

  assign flags    = flag_q;
  assign live_evt = set_src;

endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
  import llsc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_valid,
  input  logic           reg_write,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic           reg_ready,
  output logic [DW-1:0]  reg_rdata,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_we,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_rdata,
  input  logic           mem_rsp_err,
  input  logic           snoop_valid,
  input  logic [AW-1:0]  snoop_addr,
  input  logic           lock_grant_other,
  input  logic           irq_taken
);

  localparam logic [RAW-1:0] A_ADDR = RAW'(OFS_ADDR);
  localparam logic [RAW-1:0] A_DATA = RAW'(OFS_DATA);
  localparam logic [RAW-1:0] A_STAT = RAW'(OFS_STAT);

  logic                 rst_n_i;
  logic                 seq_busy;
  logic                 fetch_ok, fetch_err, store_err;
  logic [DW-1:0]        rsp_rdata;
  logic [NUM_WATCH-1:0] watch_flags, live_evt;
  logic                 wr_acc, wr_addr, wr_data;
  logic                 abort_now, store_go, orphan_store;
  logic                 resv_q, resv_d, resv_en;
  logic [AW-1:0]        addr_q;
  logic [DW-1:0]        data_q, data_d;
  logic                 data_en;

  llsc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // register port decode
  assign reg_ready = !reg_write || !seq_busy;
  assign wr_acc    = reg_valid && reg_write && reg_ready;
  assign wr_addr   = wr_acc && (reg_addr == A_ADDR);
  assign wr_data   = wr_acc && (reg_addr == A_DATA);

  assign abort_now    = (|watch_flags) || (|live_evt);
  assign store_go     = wr_data && resv_q && !abort_now;
  assign orphan_store = wr_data && !resv_q;

  // reservation state
  always_comb begin
    resv_en = wr_addr || wr_data || fetch_ok;
    resv_d  = fetch_ok && !(wr_addr || wr_data);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      resv_q <= 1'b0;
    end else if (resv_en) begin
      resv_q <= resv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
    end else if (wr_addr) begin
      addr_q <= reg_wdata[AW-1:0];
    end
  end

  // data register
  always_comb begin
    data_en = wr_data || fetch_ok;
    data_d  = wr_data ? reg_wdata : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // read mux; status writes fall through with no effect
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_ADDR)      reg_rdata = DW'(addr_q);
    else if (reg_addr == A_DATA) reg_rdata = data_q;
    else if (reg_addr == A_STAT) reg_rdata = DW'({seq_busy, watch_flags});
  end

  llsc_mem_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .fetch_go      (wr_addr),
    .store_go      (store_go),
    .go_addr       (wr_addr ? reg_wdata[AW-1:0] : addr_q),
    .go_wdata      (reg_wdata),
    .busy          (seq_busy),
    .fetch_ok      (fetch_ok),
    .fetch_err     (fetch_err),
    .store_err     (store_err),
    .rsp_rdata     (rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .mem_rsp_err   (mem_rsp_err)
  );

  llsc_watch #(.AW(AW)) u_watch (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .clr          (wr_addr),
    .resv         (resv_q),
    .resv_addr    (addr_q),
    .snoop_valid  (snoop_valid),
    .snoop_addr   (snoop_addr),
    .lock_other   (lock_grant_other),
    .irq_taken    (irq_taken),
    .fetch_err    (fetch_err),
    .store_err    (store_err),
    .orphan_store (orphan_store),
    .flags        (watch_flags),
    .live_evt     (live_evt)
  );

endmodule

// File: rtl/llsc_unit_chk.sv
module llsc_unit_chk #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int RAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_valid,
  input logic           reg_write,
  input logic [RAW-1:0] reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic           reg_ready,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic           mem_req_we,
  input logic [AW-1:0]  mem_req_addr,
  input logic           busy,
  input logic           resv,
  input logic [3:0]     flags
);

  logic wa, wd;
  assign wa = reg_valid && reg_write && reg_ready && (reg_addr == RAW'(0));
  assign wd = reg_valid && reg_write && reg_ready && (reg_addr == RAW'(4));

  AST_FETCH_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    wa |=> mem_req_valid && !mem_req_we && (mem_req_addr == $past(reg_wdata[AW-1:0]))); // R1

  AST_ADDR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wa |=> (flags == 4'b0000) && !resv); // R2

  AST_ABORT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wd && resv && (flags != 4'b0000)) |=> !mem_req_valid); // R6

  AST_ORPHAN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd && !resv) |=> !mem_req_valid && flags[0]); // R7

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && busy) |-> !reg_ready); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R10

endmodule

bind llsc_unit llsc_unit_chk #(.AW(AW), .DW(DW), .RAW(RAW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_i),
  .reg_valid     (reg_valid),
  .reg_write     (reg_write),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_ready     (reg_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .busy          (seq_busy),
  .resv          (resv_q),
  .flags         (watch_flags)
);

// File: tb/llsc_unit_tb.sv
module llsc_unit_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int RAW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_valid = 1'b0, reg_write = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic           reg_ready;
  logic [DW-1:0]  reg_rdata;
  logic           mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0]  mem_req_addr;
  logic [DW-1:0]  mem_req_wdata;
  logic           mem_rsp_valid = 1'b0;
  logic [DW-1:0]  mem_rsp_rdata = '0;
  logic           mem_rsp_err = 1'b0;
  logic           snoop_valid = 1'b0;
  logic [AW-1:0]  snoop_addr = '0;
  logic           lock_grant_other = 1'b0, irq_taken = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  llsc_unit #(.AW(AW), .DW(DW), .RAW(RAW)) u_dut (.*);

  // memory model
  logic [DW-1:0] mem [16];
  logic          pend = 1'b0;
  int            cnt = 0, lat = 0, acc = 0;
  logic          p_we;
  logic [3:0]    p_a;
  logic [DW-1:0] p_d;
  logic          err_fetch = 1'b0, err_store = 1'b0, block_ready = 1'b0;
  logic          pl_en = 1'b0;
  logic [3:0]    pl_idx = '0;
  logic [DW-1:0] pl_val = '0;

  assign mem_req_ready = !pend && !block_ready;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pl_en) mem[pl_idx] <= pl_val;
    if (!pend && mem_req_valid && !block_ready) begin
      pend <= 1'b1; cnt <= lat; acc <= acc + 1;
      p_we <= mem_req_we; p_a <= mem_req_addr[3:0]; p_d <= mem_req_wdata;
    end else if (pend) begin
      if (cnt == 0) begin
        pend <= 1'b0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[p_a];
        mem_rsp_err   <= p_we ? err_store : err_fetch;
        if (p_we && !err_store) mem[p_a] <= p_d;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [DW-1:0] v);
    @(negedge clk); pl_en = 1'b1; pl_idx = idx; pl_val = v;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [RAW-1:0] a, input logic [DW-1:0] d, output int stalls);
    stalls = 0;
    @(negedge clk); reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    while (!reg_ready) begin @(negedge clk); stalls++; #1; end
    @(negedge clk); reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [RAW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1; d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] s;
    for (int k = 0; k < 200; k++) begin
      reg_rd(4'h8, s);
      if (!s[4]) break;
    end
  endtask

  task automatic pulse_evt(input int kind, input logic [AW-1:0] a);
    @(negedge clk);
    case (kind)
      1, 2: begin snoop_valid = 1'b1; snoop_addr = a; end
      3: lock_grant_other = 1'b1;
      4: irq_taken = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    snoop_valid = 1'b0; lock_grant_other = 1'b0; irq_taken = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  idx;
    logic [31:0] init;
    logic [31:0] add;
    logic [2:0]  evt;   // 0 none,1 snoop same,2 snoop other,3 lock,4 irq,5 fetch err,6 store err
    logic [4:0]  st;
    logic        wr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd1, 32'h0000_0010, 32'h5, 3'd0, 5'h00, 1'b1},
    '{4'd2, 32'h0000_0100, 32'h1, 3'd1, 5'h01, 1'b0},
    '{4'd3, 32'h0000_0007, 32'h2, 3'd2, 5'h00, 1'b1},
    '{4'd4, 32'h0000_00AA, 32'h1, 3'd3, 5'h02, 1'b0},
    '{4'd5, 32'h0000_0055, 32'h3, 3'd4, 5'h04, 1'b0},
    '{4'd6, 32'h0000_0099, 32'h1, 3'd5, 5'h09, 1'b0},
    '{4'd7, 32'hFFFF_FFFF, 32'h1, 3'd6, 5'h08, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] r;
    int st, a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    reg_rd(4'h8, r); chk("R8 reset status", r, 32'h0);
    reg_rd(4'h4, r); chk("R1 reset data", r, 32'h0);
    chk("R10 reset no request", {31'b0, mem_req_valid}, 32'h0);

    // vector table
    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      preload(v.idx, v.init);
      err_fetch = (v.evt == 3'd5);
      err_store = 1'b0;
      reg_wr(4'h0, {28'b0, v.idx}, st);
      wait_idle();
      if (v.evt != 3'd5) begin
        reg_rd(4'h4, r); chk("R1 fetched data", r, v.init);
      end
      if (v.evt == 3'd1) pulse_evt(1, AW'(v.idx));
      if (v.evt == 3'd2) pulse_evt(2, AW'(v.idx) + 16'd1);
      if (v.evt == 3'd3 || v.evt == 3'd4) pulse_evt(int'(v.evt), '0);
      err_fetch = 1'b0;
      err_store = (v.evt == 3'd6);
      reg_wr(4'h4, v.init + v.add, st);
      wait_idle();
      err_store = 1'b0;
      reg_rd(4'h8, r); chk("R5 R4 R6 R7 status", r, {27'b0, v.st});
      chk("R4 R6 memory word", mem[v.idx], v.wr ? v.init + v.add : v.init);
    end

    // R2: a new address write clears flags left by the failed store
    reg_wr(4'h0, 32'd1, st); wait_idle();
    reg_rd(4'h8, r); chk("R2 flags cleared", r, 32'h0);
    // R11: address readback and ignored status write
    reg_rd(4'h0, r); chk("R11 address readback", r, 32'd1);
    pulse_evt(4, '0);
    reg_wr(4'h8, 32'h0, st);
    reg_rd(4'h8, r); chk("R11 status write ignored", r, 32'h4);

    // R3: reads cause no access
    a0 = acc;
    for (int k = 0; k < 5; k++) reg_rd(4'h4, r);
    reg_rd(4'h8, r);
    chk("R3 reads no access", acc, a0);

    // R9: events after a completed store are not recorded
    preload(4'd9, 32'h30);
    reg_wr(4'h0, 32'd9, st); wait_idle();
    reg_wr(4'h4, 32'h31, st); wait_idle();
    pulse_evt(4, '0); pulse_evt(3, '0); pulse_evt(1, 16'd9);
    reg_rd(4'h8, r); chk("R9 events outside reservation", r, 32'h0);

    // R7: data write after completion: no reservation
    a0 = acc;
    reg_wr(4'h4, 32'h77, st); wait_idle();
    reg_rd(4'h8, r); chk("R7 orphan status", r, 32'h1);
    chk("R7 orphan no access", acc, a0);
    chk("R7 memory unchanged", mem[9], 32'h31);

    // R6: interrupt in the same cycle as the data write
    preload(4'd8, 32'h20);
    reg_wr(4'h0, 32'd8, st); wait_idle();
    a0 = acc;
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h21; irq_taken = 1'b1;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; irq_taken = 1'b0;
    wait_idle();
    reg_rd(4'h8, r); chk("R6 same-cycle event status", r, 32'h4);
    chk("R6 same-cycle no access", acc, a0);
    chk("R6 same-cycle memory", mem[8], 32'h20);

    // R8: busy bit and stalled data write behind slow fetch
    lat = 6;
    preload(4'd10, 32'h40);
    reg_wr(4'h0, 32'd10, st);
    reg_rd(4'h8, r); chk("R8 busy during fetch", {31'b0, r[4]}, 32'h1);
    reg_wr(4'h4, 32'h41, st);
    chk("R8 data write stalled", {31'b0, st > 0}, 32'h1);
    wait_idle();
    reg_rd(4'h8, r); chk("R8 stalled write succeeds", r, 32'h0);
    chk("R4 stalled store lands", mem[10], 32'h41);
    lat = 0;

    // R10: request held while memory not ready
    block_ready = 1'b1;
    a0 = acc;
    reg_wr(4'h0, 32'd11, st);
    repeat (3) @(negedge clk);
    chk("R10 request held valid", {31'b0, mem_req_valid}, 32'h1);
    chk("R10 request address held", {16'b0, mem_req_addr}, 32'd11);
    chk("R10 no acceptance", acc, a0);
    block_ready = 1'b0;
    wait_idle();
    chk("R10 single access", acc, a0 + 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule